// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block holds a processor core's interrupt enable flip-flop and its run/halt state, and arbitrates between one non-maskable request and a parameterised number of maskable request levels. The core signals the end of each instruction with a one-cycle boundary pulse. On that pulse, or on any cycle while the core is halted, the controller picks the winning request. It then raises a one-cycle take pulse together with a 16-bit restart address, which the core uses as the target of an implied call.

The enable flip-flop is set and cleared by strobes from the core's instruction decoder. Reset clears it, and so does every accepted request, so a service routine runs with maskable requests blocked until it enables them again. The non-maskable line bypasses the flip-flop and all masks. By default the topmost maskable level is edge-captured and held until it is served. The lower levels are sampled as levels.

A halt strobe makes the core stop at the next instruction boundary. Only an accepted request or reset takes it out of the halted state again.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While reset is asserted and on release, ie_o, halted_o and take_o are all 0.
- R2: An ie_set_i strobe makes ie_o 1 from the next cycle. An ie_clr_i strobe makes it 0 from the next cycle. When both strobes are high together, ie_o becomes 0. Without a strobe or an acceptance, ie_o keeps its value.
- R3: Every acceptance (take_o high) makes ie_o 0 in the next cycle, even when ie_set_i is high in the same cycle.
- R4: Requests are evaluated only in a cycle where boundary_i is high or the core is halted. take_o is combinational, and vector_o carries the restart address in that same cycle.
- R5: nmi_i is accepted whatever the values of ie_o and lvl_mask_i, with vector 16'h0024.
- R6: Maskable level k (lvl_req_i[k]) is accepted only when ie_o is 1 and lvl_mask_i[k] is 0. Its vector is 16'h002C + 8*k, so level 0 gives 002C, level 1 gives 0034 and level 2 gives 003C.
- R7: When several requests are eligible, one is accepted in this order: nmi_i first, then lvl_req_i[2], then lvl_req_i[1], then lvl_req_i[0].
- R8: A rising edge on lvl_req_i[2] is captured at the clock edge that sees it, and stays pending until that level is accepted, even after the input has fallen. Holding the input high after an acceptance does not raise the request again.
- R9: lvl_req_i[1:0] are level-sensitive. A pulse that has ended before an evaluation cycle is not taken.
- R10: After a halt_req_i strobe, halted_o rises in the cycle after the next boundary_i pulse, or after the same cycle when both coincide.
- R11: While halted, boundary pulses and ineligible requests leave halted_o at 1. An acceptance drops halted_o to 0 in the same cycle as take_o. Reset also clears halted_o.
- R12: An acceptance at the boundary that would complete a pending halt cancels that halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ie_set_i | input | 1 | Enable-interrupts strobe |
| ie_clr_i | input | 1 | Disable-interrupts strobe |
| halt_req_i | input | 1 | Halt strobe from the decoder |
| boundary_i | input | 1 | Instruction boundary pulse |
| nmi_i | input | 1 | Non-maskable request |
| lvl_req_i | input | 3 | Maskable requests, bit 2 highest |
| lvl_mask_i | input | 3 | Per-level mask, 1 blocks the level |
| halted_o | output | 1 | Core is halted |
| take_o | output | 1 | Request accepted this cycle |
| vector_o | output | 16 | Restart address, valid with take_o |
| ie_o | output | 1 | Interrupt enable flip-flop |

## Verification
On every cycle the assertions check how the enable flip-flop responds to the strobes and to acceptances, that a halted state persists until something is taken, that an accepted maskable request always had the flip-flop set, and that the non-maskable line wins on every boundary. Some behaviour depends on history across several cycles, so only the bench's scenarios can show it. This covers the edge capture and its clearing, the loss of a short pulse on a level line, a halt cancelled by a coinciding acceptance, and which masked level yields to which.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_NMI  = 2'd1,
      SRC_LVL  = 2'd2
   } irq_src_e;

   // restart address of maskable level idx
   function automatic logic [31:0] lvl_addr(input int base, input int step, input int idx);
      return 32'(base + step * idx);
   endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int                N_LVL    = 3,
   parameter int                IDX_W    = 2,
   parameter logic [N_LVL-1:0]  LVL_EDGE = 3'b100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LVL-1:0]  req_i,
   input  logic              ack_i,
   input  logic [IDX_W-1:0]  ack_idx_i,
   output logic [N_LVL-1:0]  pend_o
);

   for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
      if (LVL_EDGE[i]) begin : g_edge
         logic prev_q;
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= req_i[i];
               if (req_i[i] && !prev_q) begin
                  pend_q <= 1'b1;
               end else if (ack_i && (ack_idx_i == IDX_W'(i))) begin
                  pend_q <= 1'b0;
               end
            end
         end
         assign pend_o[i] = pend_q;
      end else begin : g_level
         assign pend_o[i] = req_i[i];
      end
   end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import irq_halt_pkg::*;
#(
   parameter int N_LVL    = 3,
   parameter int IDX_W    = 2,
   parameter int VEC_W    = 16,
   parameter int NMI_VEC  = 'h24,
   parameter int LVL_BASE = 'h2C,
   parameter int LVL_STEP = 8
) (
   input  logic              eval_i,
   input  logic              nmi_i,
   input  logic              ie_i,
   input  logic [N_LVL-1:0]  pend_i,
   input  logic [N_LVL-1:0]  mask_i,
   output logic              take_o,
   output logic              lvl_take_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [VEC_W-1:0]  vector_o
);

   logic [N_LVL-1:0] elig;
   logic             lvl_hit;
   irq_src_e         src;

   assign elig = pend_i & ~mask_i & {N_LVL{ie_i}};

   // ascending scan: the highest eligible level is kept
   always_comb begin
      lvl_hit = 1'b0;
      idx_o   = '0;
      for (int i = 0; i < N_LVL; i++) begin
         if (elig[i]) begin
            lvl_hit = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (!eval_i)      src = SRC_NONE;
      else if (nmi_i)   src = SRC_NMI;
      else if (lvl_hit) src = SRC_LVL;
      else              src = SRC_NONE;
   end

   always_comb begin
      case (src)
         SRC_NMI: vector_o = VEC_W'(NMI_VEC);
         SRC_LVL: vector_o = VEC_W'(lvl_addr(LVL_BASE, LVL_STEP, int'(idx_o)));
         default: vector_o = '0;
      endcase
   end

   assign take_o     = (src != SRC_NONE);
   assign lvl_take_o = (src == SRC_LVL);

endmodule

// File: rtl/irq_run_state.sv
module irq_run_state (
   input  logic clk,
   input  logic rst_n,
   input  logic ie_set_i,
   input  logic ie_clr_i,
   input  logic halt_req_i,
   input  logic boundary_i,
   input  logic take_i,
   output logic ie_o,
   output logic halted_q_o,
   output logic eval_o
);

   logic ie_q;
   logic halt_pend_q;
   logic halted_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else if (take_i || ie_clr_i) begin
         ie_q <= 1'b0;
      end else if (ie_set_i) begin
         ie_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_pend_q <= 1'b0;
         halted_q    <= 1'b0;
      end else if (take_i) begin
         halt_pend_q <= 1'b0;
         halted_q    <= 1'b0;
      end else if (boundary_i && (halt_pend_q || halt_req_i)) begin
         halt_pend_q <= 1'b0;
         halted_q    <= 1'b1;
      end else if (halt_req_i) begin
         halt_pend_q <= 1'b1;
      end
   end

   assign ie_o       = ie_q;
   assign halted_q_o = halted_q;
   assign eval_o     = boundary_i || halted_q;

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
   parameter int                N_LVL    = 3,
   parameter int                VEC_W    = 16,
   parameter int                NMI_VEC  = 'h24,
   parameter int                LVL_BASE = 'h2C,
   parameter int                LVL_STEP = 8,
   parameter logic [N_LVL-1:0]  LVL_EDGE = 3'b100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ie_set_i,
   input  logic              ie_clr_i,
   input  logic              halt_req_i,
   input  logic              boundary_i,
   input  logic              nmi_i,
   input  logic [N_LVL-1:0]  lvl_req_i,
   input  logic [N_LVL-1:0]  lvl_mask_i,
   output logic              halted_o,
   output logic              take_o,
   output logic [VEC_W-1:0]  vector_o,
   output logic              ie_o
);

   localparam int IDX_W = (N_LVL > 1) ? $clog2(N_LVL) : 1;

   if (N_LVL < 1 || N_LVL > 8) begin : g_bad_lvl
      $error("irq_halt_ctrl: N_LVL must lie in 1..8");
   end
   if (VEC_W < 8 || VEC_W > 32) begin : g_bad_vec
      $error("irq_halt_ctrl: VEC_W must lie in 8..32");
   end
   if (LVL_STEP < 1) begin : g_bad_step
      $error("irq_halt_ctrl: LVL_STEP must be positive");
   end

   logic              eval;
   logic              halted_q;
   logic              lvl_take;
   logic [IDX_W-1:0]  take_idx;
   logic [N_LVL-1:0]  pend;

   irq_run_state u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .ie_set_i   (ie_set_i),
      .ie_clr_i   (ie_clr_i),
      .halt_req_i (halt_req_i),
      .boundary_i (boundary_i),
      .take_i     (take_o),
      .ie_o       (ie_o),
      .halted_q_o (halted_q),
      .eval_o     (eval)
   );

   irq_edge_capture #(
      .N_LVL    (N_LVL),
      .IDX_W    (IDX_W),
      .LVL_EDGE (LVL_EDGE)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (lvl_req_i),
      .ack_i     (lvl_take),
      .ack_idx_i (take_idx),
      .pend_o    (pend)
   );

   irq_prio_sel #(
      .N_LVL    (N_LVL),
      .IDX_W    (IDX_W),
      .VEC_W    (VEC_W),
      .NMI_VEC  (NMI_VEC),
      .LVL_BASE (LVL_BASE),
      .LVL_STEP (LVL_STEP)
   ) u_sel (
      .eval_i     (eval),
      .nmi_i      (nmi_i),
      .ie_i       (ie_o),
      .pend_i     (pend),
      .mask_i     (lvl_mask_i),
      .take_o     (take_o),
      .lvl_take_o (lvl_take),
      .idx_o      (take_idx),
      .vector_o   (vector_o)
   );

   // an acceptance while halted wakes the core in the same cycle
   assign halted_o = halted_q && !take_o;

endmodule

// File: rtl/irq_halt_ctrl_chk.sv
module irq_halt_ctrl_chk #(
   parameter int N_LVL   = 3,
   parameter int VEC_W   = 16,
   parameter int NMI_VEC = 'h24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ie_set_i,
   input logic              ie_clr_i,
   input logic              boundary_i,
   input logic              nmi_i,
   input logic              halted_o,
   input logic              take_o,
   input logic [VEC_W-1:0]  vector_o,
   input logic              ie_o
);

   a_r2_ie_clr: assert property (@(posedge clk) disable iff (!rst_n)
      ie_clr_i |=> !ie_o);

   a_r2_ie_set: assert property (@(posedge clk) disable iff (!rst_n)
      ie_set_i && !ie_clr_i && !take_o |=> ie_o);

   a_r2_ie_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_set_i && !ie_clr_i && !take_o |=> $stable(ie_o));

   a_r3_ack_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !ie_o);

   a_r5_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_i && boundary_i |-> take_o && (vector_o == VEC_W'(NMI_VEC)));

   a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && (vector_o != VEC_W'(NMI_VEC)) |-> ie_o);

   a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o || take_o);

   a_r11_wake_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !halted_o);

endmodule

bind irq_halt_ctrl irq_halt_ctrl_chk #(
   .N_LVL   (N_LVL),
   .VEC_W   (VEC_W),
   .NMI_VEC (NMI_VEC)
) u_chk (.*);

// File: tb/irq_halt_ctrl_bench.sv
`timescale 1ns/100ps
module irq_halt_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ie_set, ie_clr, halt_req, boundary, nmi;
   logic [2:0]  lvl_req, lvl_mask;
   logic        halted, take, ie;
   logic [15:0] vec;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   irq_halt_ctrl u_irq_halt_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ie_set_i   (ie_set),
      .ie_clr_i   (ie_clr),
      .halt_req_i (halt_req),
      .boundary_i (boundary),
      .nmi_i      (nmi),
      .lvl_req_i  (lvl_req),
      .lvl_mask_i (lvl_mask),
      .halted_o   (halted),
      .take_o     (take),
      .vector_o   (vec),
      .ie_o       (ie)
   );

   // {ie, nmi, req[1:0], mask[2:0], boundary, exp_take, exp_vec}
   localparam int NROW = 12;
   localparam logic [24:0] TBL [NROW] = '{
      {1'b1, 1'b0, 2'b01, 3'b000, 1'b1, 1'b1, 16'h002C},
      {1'b1, 1'b0, 2'b10, 3'b000, 1'b1, 1'b1, 16'h0034},
      {1'b1, 1'b0, 2'b11, 3'b000, 1'b1, 1'b1, 16'h0034},
      {1'b0, 1'b0, 2'b11, 3'b000, 1'b1, 1'b0, 16'h0000},
      {1'b0, 1'b1, 2'b00, 3'b000, 1'b1, 1'b1, 16'h0024},
      {1'b1, 1'b1, 2'b11, 3'b000, 1'b1, 1'b1, 16'h0024},
      {1'b1, 1'b0, 2'b11, 3'b010, 1'b1, 1'b1, 16'h002C},
      {1'b1, 1'b0, 2'b11, 3'b011, 1'b1, 1'b0, 16'h0000},
      {1'b1, 1'b0, 2'b01, 3'b000, 1'b0, 1'b0, 16'h0000},
      {1'b1, 1'b1, 2'b00, 3'b111, 1'b1, 1'b1, 16'h0024},
      {1'b1, 1'b0, 2'b10, 3'b001, 1'b1, 1'b1, 16'h0034},
      {1'b1, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0, 16'h0000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic quiet();
      ie_set = 0; ie_clr = 0; halt_req = 0; boundary = 0; nmi = 0;
      lvl_req = '0; lvl_mask = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      quiet();
      repeat (3) cyc();
      #1;
      chk("R1 ie in reset", ie, 0);
      chk("R1 halted in reset", halted, 0);
      chk("R1 take in reset", take, 0);
      cyc(); rst_n = 1'b1;
      #1;
      chk("R1 ie after release", ie, 0);

      // table walk: R4 R5 R6 R7
      for (int k = 0; k < NROW; k++) begin
         cyc(); ie_set = TBL[k][24]; ie_clr = !TBL[k][24];
         cyc(); ie_set = 0; ie_clr = 0;
         nmi = TBL[k][23]; lvl_req[1:0] = TBL[k][22:21];
         lvl_mask = TBL[k][20:18]; boundary = TBL[k][17];
         #1;
         chk($sformatf("R4 R5 R6 R7 row %0d take", k), take, TBL[k][16]);
         if (TBL[k][16]) chk($sformatf("R5 R6 row %0d vector", k), vec, TBL[k][15:0]);
         cyc(); quiet();
      end

      // R2 strobes
      cyc(); ie_set = 1;
      cyc(); ie_set = 0; #1 chk("R2 set", ie, 1);
      cyc(); ie_clr = 1;
      cyc(); ie_clr = 0; #1 chk("R2 clear", ie, 0);
      cyc(); ie_set = 1; ie_clr = 1;
      cyc(); ie_set = 0; ie_clr = 0; #1 chk("R2 both strobes", ie, 0);

      // R3 acceptance beats a simultaneous enable
      cyc(); ie_set = 1;
      cyc(); lvl_req[0] = 1; boundary = 1; #1 chk("R3 take", take, 1);
      cyc(); quiet(); #1 chk("R3 ie cleared", ie, 0);
      chk("R4 take single cycle", take, 0);

      // R9 short pulse on level line is lost
      cyc(); ie_set = 1;
      cyc(); ie_set = 0; lvl_req[0] = 1;
      cyc(); lvl_req[0] = 0; boundary = 1; #1 chk("R9 pulse dropped", take, 0);
      cyc(); boundary = 0;

      // R8 edge captured while masked, served later
      lvl_mask[2] = 1; lvl_req[2] = 1;
      cyc(); lvl_req[2] = 0;
      cyc(); boundary = 1; #1 chk("R8 masked not taken", take, 0);
      cyc(); boundary = 0; lvl_mask = '0;
      cyc(); boundary = 1; lvl_req[1] = 1; #1
      chk("R8 latched take", take, 1);
      chk("R7 level2 over level1 vector", vec, 16'h003C);
      cyc(); boundary = 0; lvl_req[1] = 0; ie_set = 1;
      cyc(); ie_set = 0; boundary = 1; #1 chk("R8 cleared by ack", take, 0);
      cyc(); boundary = 0; lvl_req[2] = 1;
      cyc();
      cyc(); boundary = 1; #1
      chk("R8 held edge take", take, 1);
      chk("R8 held edge vector", vec, 16'h003C);
      cyc(); boundary = 0; ie_set = 1;
      cyc(); ie_set = 0; boundary = 1; #1 chk("R8 held high no retake", take, 0);
      cyc(); quiet(); ie_clr = 1;
      cyc(); ie_clr = 0;

      // R10 halt waits for boundary
      cyc(); halt_req = 1;
      cyc(); halt_req = 0; #1 chk("R10 not before boundary", halted, 0);
      boundary = 1;
      cyc(); boundary = 0; #1 chk("R10 halted after boundary", halted, 1);

      // R11 halted behaviour
      boundary = 1;
      cyc(); boundary = 0; #1 chk("R11 boundary ignored", halted, 1);
      lvl_req[0] = 1;
      cyc(); #1
      chk("R11 disabled req no wake", halted, 1);
      chk("R11 disabled req no take", take, 0);
      lvl_req[0] = 0; nmi = 1; #1
      chk("R11 nmi take", take, 1);
      chk("R11 nmi vector", vec, 16'h0024);
      chk("R11 wake same cycle", halted, 0);
      cyc(); nmi = 0; #1 chk("R11 stays awake", halted, 0);

      cyc(); halt_req = 1; boundary = 1;
      cyc(); halt_req = 0; boundary = 0; #1 chk("R10 coincident boundary", halted, 1);
      cyc(); ie_set = 1;
      cyc(); ie_set = 0; lvl_req[1] = 1; #1
      chk("R11 maskable wake take", take, 1);
      chk("R11 maskable wake vector", vec, 16'h0034);
      chk("R11 maskable wake halted", halted, 0);
      cyc(); lvl_req[1] = 0; #1 chk("R11 awake after maskable", halted, 0);

      // R12 acceptance cancels halt
      cyc(); ie_set = 1;
      cyc(); ie_set = 0; halt_req = 1; boundary = 1; lvl_req[0] = 1; #1
      chk("R12 take", take, 1);
      cyc(); quiet(); #1 chk("R12 halt cancelled", halted, 0);
      cyc(); boundary = 1;
      cyc(); boundary = 0; #1 chk("R12 halt not pending", halted, 0);

      // R11 reset leaves halt
      cyc(); halt_req = 1; boundary = 1;
      cyc(); quiet(); #1 chk("R11 halted before reset", halted, 1);
      rst_n = 0;
      cyc(); #1 chk("R11 reset clears halt", halted, 0);
      rst_n = 1;
      cyc();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule